// File: doc/BRIEF.md
# Hot-plug I/O expander sequencer

This block keeps a bank of hot-plug control outputs and status inputs, which sit on an external I/O expander, consistent with the switch's own view of them. The expander is reached through a byte-level SMBus master that is shared with the configuration loader. The port hot-plug logic presents the output bits it wants on `out_image`. Whenever any of those bits changes, the sequencer sends the complete image to the expander in a single write. It never sends a single-bit update.

The expander reports that any of its inputs has changed by pulling an active-low interrupt low. That interrupt arrives on a pin that can also be a plain general-purpose I/O. It therefore only counts while the pin's alternate function is enabled. While the synchronised interrupt is low, the sequencer performs bulk reads of every input. It hands each returned byte to the hot-plug logic together with a one-cycle strobe.

Access to the shared bus uses a request/grant handshake. When a write and a read are both pending, the write goes first. A NACK from the bus ends the attempt, sets a sticky error flag, and causes exactly one retry.

Top module: `hpx_seq`

## Requirements
- R1: While `cfg_done` is low, the sequencer starts no transaction and `bus_req` stays low. Pending work is held until `cfg_done` is high.
- R2: After reset, the first transaction is a write of the current `out_image`. After that, any change of `out_image` leads to one write (`txn_write`=1) whose `txn_wdata` is the full image as sampled in the cycle the write was launched.
- R3: Changes of `out_image` that arrive while a write is waiting or in flight produce exactly one further write after it completes. That write carries the image current at its launch, so several changes merge into one write.
- R4: `exp_int_n` is active low and passes through a two-flop synchroniser. A read (`txn_write`=0) is requested only when the synchronised level is low and `int_alt_en` is 1. With `int_alt_en`=0 the line has no effect on the bus.
- R5: The interrupt is level-sensitive. Reads keep being issued back to back for as long as the synchronised interrupt stays low and enabled. They stop once it is high.
- R6: If a write and a read are both pending when the sequencer is idle, the write is launched first.
- R7: `bus_req` rises in the cycle after a transaction is launched. It stays high until that transaction's `txn_done` has been accepted. `txn_start` is high only in a cycle where `bus_req` and `bus_gnt` are both high, and for one cycle per attempt.
- R8: A `txn_done` with `txn_nack`=1 sets `err_flag`, which stays set until reset. The first NACK of a transaction causes one retry with the same kind and data. A second NACK drops the transaction.
- R9: After a read completes without NACK, `in_status` takes `txn_rdata` and `in_strobe` is high for exactly one cycle, both in the cycle after `txn_done`. At all other times `in_status` holds its value. After reset, `in_status`, `in_strobe` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Initial configuration load has finished |
| int_alt_en | input | 1 | Interrupt alternate function of the shared pin is enabled |
| exp_int_n | input | 1 | Asynchronous active-low expander interrupt |
| out_image | input | W | Desired values of all expander outputs |
| bus_req | output | 1 | Request for the shared SMBus master |
| bus_gnt | input | 1 | Grant of the shared SMBus master |
| txn_start | output | 1 | Start one byte transaction (one cycle) |
| txn_write | output | 1 | 1 = write output image, 0 = read inputs |
| txn_wdata | output | W | Byte to write |
| txn_done | input | 1 | Transaction finished (one cycle) |
| txn_nack | input | 1 | Finished transaction was not acknowledged |
| txn_rdata | input | W | Byte returned by a read |
| in_status | output | W | Last captured expander inputs |
| in_strobe | output | 1 | One-cycle pulse when `in_status` is updated |
| err_flag | output | 1 | Sticky bus error flag |

## Verification
The results have fixed latencies:
- **Output change.** A change on `out_image` sampled at one edge sets the pending flag at that edge. The write is launched at the next edge, so `bus_req` is seen one cycle later. `txn_start` then follows in the first cycle that has a grant.
- **Interrupt.** A falling `exp_int_n` needs two edges in the synchroniser. The read is launched at the third edge.
- **Read completion.** A `txn_done` sampled at an edge updates `in_status`, `in_strobe` and `err_flag` from that same edge.

The bench holds a reference model that advances at every rising edge from the same inputs. It compares all outputs 7 ns after each falling edge. Inputs and bus responses are driven 0 to 4 ns after the falling edge, so every comparison sees the values settled for the coming edge.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_BUSY = 2'd2
    } seq_state_e;

endpackage

// File: rtl/hpx_sync.sv
module hpx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_async;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d_async};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hpx_dirty.sv
module hpx_dirty #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] image,
    input  logic         clr,
    output logic         dirty
);

    typedef struct packed {
        logic         pend;
        logic [W-1:0] prev;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.prev = image;
        // a launch captures the live image, so it covers a same-cycle change
        if (clr)                    trk_d.pend = 1'b0;
        else if (image != trk_q.prev) trk_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.pend <= 1'b1;   // push the image once after start-up
            trk_q.prev <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign dirty = trk_q.pend;

endmodule

// File: rtl/hpx_fsm.sv
module hpx_fsm
    import hpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_done,
    input  logic         wr_pend,
    input  logic         rd_pend,
    input  logic [W-1:0] image,
    input  logic         bus_gnt,
    input  logic         txn_done,
    input  logic         txn_nack,
    input  logic [W-1:0] txn_rdata,
    output logic         launch_wr,
    output logic         bus_req,
    output logic         txn_start,
    output logic         txn_write,
    output logic [W-1:0] txn_wdata,
    output logic [W-1:0] in_status,
    output logic         in_strobe,
    output logic         err_flag
);

    typedef struct packed {
        seq_state_e   st;
        logic         is_wr;
        logic [W-1:0] data;
        logic         retried;
        logic         err;
        logic [W-1:0] status;
        logic         stb;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.stb   = 1'b0;
        launch_wr = 1'b0;
        txn_start = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (cfg_done) begin
                    if (wr_pend) begin
                        launch_wr = 1'b1;
                        s_d.is_wr = 1'b1;
                        s_d.data  = image;
                        s_d.st    = SEQ_WAIT;
                    end else if (rd_pend) begin
                        s_d.is_wr = 1'b0;
                        s_d.st    = SEQ_WAIT;
                    end
                end
            end
            SEQ_WAIT: begin
                if (bus_gnt) begin
                    txn_start = 1'b1;
                    s_d.st    = SEQ_BUSY;
                end
            end
            SEQ_BUSY: begin
                if (txn_done) begin
                    if (txn_nack) begin
                        s_d.err = 1'b1;
                        if (!s_q.retried) begin
                            s_d.retried = 1'b1;
                            s_d.st      = SEQ_WAIT;
                        end else begin
                            s_d.retried = 1'b0;
                            s_d.st      = SEQ_IDLE;
                        end
                    end else begin
                        s_d.retried = 1'b0;
                        s_d.st      = SEQ_IDLE;
                        if (!s_q.is_wr) begin
                            s_d.status = txn_rdata;
                            s_d.stb    = 1'b1;
                        end
                    end
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st      <= SEQ_IDLE;
            s_q.is_wr   <= 1'b0;
            s_q.data    <= '0;
            s_q.retried <= 1'b0;
            s_q.err     <= 1'b0;
            s_q.status  <= '0;
            s_q.stb     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_req   = (s_q.st != SEQ_IDLE);
    assign txn_write = s_q.is_wr;
    assign txn_wdata = s_q.data;
    assign in_status = s_q.status;
    assign in_strobe = s_q.stb;
    assign err_flag  = s_q.err;

endmodule

// File: rtl/hpx_seq.sv
module hpx_seq #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_done,
    input  logic         int_alt_en,
    input  logic         exp_int_n,
    input  logic [W-1:0] out_image,
    output logic         bus_req,
    input  logic         bus_gnt,
    output logic         txn_start,
    output logic         txn_write,
    output logic [W-1:0] txn_wdata,
    input  logic         txn_done,
    input  logic         txn_nack,
    input  logic [W-1:0] txn_rdata,
    output logic [W-1:0] in_status,
    output logic         in_strobe,
    output logic         err_flag
);

    logic int_n_sync;
    logic wr_pend;
    logic rd_pend;
    logic launch_wr;

    hpx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (exp_int_n),
        .q       (int_n_sync)
    );

    assign rd_pend = int_alt_en & ~int_n_sync;

    hpx_dirty #(.W(W)) u_dirty (
        .clk   (clk),
        .rst_n (rst_n),
        .image (out_image),
        .clr   (launch_wr),
        .dirty (wr_pend)
    );

    hpx_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_done  (cfg_done),
        .wr_pend   (wr_pend),
        .rd_pend   (rd_pend),
        .image     (out_image),
        .bus_gnt   (bus_gnt),
        .txn_done  (txn_done),
        .txn_nack  (txn_nack),
        .txn_rdata (txn_rdata),
        .launch_wr (launch_wr),
        .bus_req   (bus_req),
        .txn_start (txn_start),
        .txn_write (txn_write),
        .txn_wdata (txn_wdata),
        .in_status (in_status),
        .in_strobe (in_strobe),
        .err_flag  (err_flag)
    );

endmodule

// File: rtl/hpx_seq_chk.sv
module hpx_seq_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_done,
    input logic         bus_req,
    input logic         bus_gnt,
    input logic         txn_start,
    input logic         txn_done,
    input logic         txn_nack,
    input logic [W-1:0] in_status,
    input logic         in_strobe,
    input logic         err_flag
);

    AST_HOLD_OFF_BEFORE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done && !bus_req) |=> !bus_req); // R1

    AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |-> (bus_req && bus_gnt)); // R7

    AST_REQ_HELD_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        txn_start |=> (bus_req && !txn_start)); // R7

    AST_NACK_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !txn_start && txn_done && txn_nack) |=> err_flag); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> !in_strobe); // R9

    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_strobe |-> $stable(in_status)); // R9

endmodule

bind hpx_seq hpx_seq_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_done  (cfg_done),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .txn_start (txn_start),
    .txn_done  (txn_done),
    .txn_nack  (txn_nack),
    .in_status (in_status),
    .in_strobe (in_strobe),
    .err_flag  (err_flag)
);

// File: tb/hpx_seq_test.sv
`timescale 1ns/1ps
module hpx_seq_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_done = 1'b0;
    logic         int_alt_en = 1'b0;
    logic         exp_int_n = 1'b1;
    logic [W-1:0] out_image = 8'h3C;
    logic         bus_req;
    logic         bus_gnt = 1'b0;
    logic         txn_start;
    logic         txn_write;
    logic [W-1:0] txn_wdata;
    logic         txn_done = 1'b0;
    logic         txn_nack = 1'b0;
    logic [W-1:0] txn_rdata = '0;
    logic [W-1:0] in_status;
    logic         in_strobe;
    logic         err_flag;

    always #10 clk = ~clk;   // 50 MHz

    hpx_seq #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .int_alt_en(int_alt_en),
        .exp_int_n(exp_int_n), .out_image(out_image), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .txn_start(txn_start), .txn_write(txn_write),
        .txn_wdata(txn_wdata), .txn_done(txn_done), .txn_nack(txn_nack),
        .txn_rdata(txn_rdata), .in_status(in_status), .in_strobe(in_strobe),
        .err_flag(err_flag)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // ---------------- bus agent (drives grant and completions) -----------
    bit           gnt_en = 1;
    int           nack_left = 0;
    logic [W-1:0] rd_val = '0;
    bit           a_busy = 0;
    int           a_cnt = 0;
    bit           a_wr = 0;
    logic [W-1:0] a_data = '0;
    int           att = 0, wr_ok = 0, rd_ok = 0;
    logic [W-1:0] last_wdata = '0;
    bit           arm_first = 0;
    int           first_kind = -1;

    always @(negedge clk) begin
        #3;
        txn_done  = 1'b0;
        txn_nack  = 1'b0;
        txn_rdata = rd_val;
        if (!rst_n) begin
            a_busy  = 0;
            bus_gnt = 1'b0;
        end else begin
            if (a_busy) begin
                if (a_cnt == 0) begin
                    txn_done = 1'b1;
                    a_busy   = 0;
                    if (nack_left > 0) begin
                        txn_nack = 1'b1;
                        nack_left--;
                    end else if (a_wr) begin
                        wr_ok++;
                        last_wdata = a_data;
                    end else begin
                        rd_ok++;
                    end
                end else begin
                    a_cnt--;
                end
            end
            bus_gnt = bus_req & gnt_en;
            #1;
            if (txn_start) begin
                a_busy = 1;
                a_cnt  = 2;
                a_wr   = txn_write;
                a_data = txn_wdata;
                att++;
                if (arm_first && first_kind < 0) first_kind = txn_write ? 1 : 0;
            end
        end
    end

    // ---------------- behavioural reference model ------------------------
    int           m_phase = 0;     // 0 idle, 1 waiting for grant, 2 on the bus
    bit           m_kind = 0, m_dirty = 1, m_retry = 0, m_err = 0, m_stb = 0;
    bit           ms1 = 1, ms2 = 1;
    logic [W-1:0] m_data = '0, m_prev = '0, m_stat = '0;

    always @(posedge clk) begin
        int           np;
        bit           nk, nr, ne, nsb, launch;
        logic [W-1:0] nd, nst;
        if (!rst_n) begin
            m_phase = 0; m_kind = 0; m_dirty = 1; m_retry = 0; m_err = 0; m_stb = 0;
            ms1 = 1; ms2 = 1; m_data = '0; m_prev = '0; m_stat = '0;
        end else begin
            np = m_phase; nk = m_kind; nd = m_data; nr = m_retry; ne = m_err;
            nst = m_stat; nsb = 0; launch = 0;
            if (m_phase == 0) begin
                if (cfg_done) begin
                    if (m_dirty) begin launch = 1; nk = 1; nd = out_image; np = 1; end
                    else if (int_alt_en && !ms2) begin nk = 0; np = 1; end
                end
            end else if (m_phase == 1) begin
                if (bus_gnt) np = 2;
            end else if (txn_done) begin
                np = 0;
                if (txn_nack) begin
                    ne = 1;
                    if (!m_retry) begin nr = 1; np = 1; end
                    else nr = 0;
                end else begin
                    nr = 0;
                    if (!m_kind) begin nst = txn_rdata; nsb = 1; end
                end
            end
            m_dirty = launch ? 1'b0 : (m_dirty || (out_image != m_prev));
            m_prev  = out_image;
            ms2 = ms1; ms1 = exp_int_n;
            m_phase = np; m_kind = nk; m_data = nd; m_retry = nr; m_err = ne;
            m_stat = nst; m_stb = nsb;
        end
    end

    always @(negedge clk) begin
        bit exp_start;
        #7;
        if (rst_n && !finished) begin
            exp_start = (m_phase == 1) && bus_gnt;
            chk(bus_req == (m_phase != 0), "R7 bus_req vs model", bus_req, m_phase != 0);
            chk(txn_start == exp_start, "R7 txn_start vs model", txn_start, exp_start);
            if (exp_start) begin
                chk(txn_write == m_kind, "R6 txn_write vs model", txn_write, m_kind);
                if (m_kind) chk(txn_wdata == m_data, "R2 txn_wdata vs model", txn_wdata, m_data);
            end
            chk(in_strobe == m_stb, "R9 in_strobe vs model", in_strobe, m_stb);
            chk(in_status == m_stat, "R9 in_status vs model", in_status, m_stat);
            chk(err_flag == m_err, "R8 err_flag vs model", err_flag, m_err);
        end
    end

    // ---------------- watchdog ---------------------------------------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- directed stimulus ------------------------------------
    initial begin
        int b_wr, b_att, b_rd;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        #8;
        chk(bus_req == 0, "R9 reset bus_req", bus_req, 0);
        chk(in_strobe == 0, "R9 reset in_strobe", in_strobe, 0);
        chk(in_status == 0, "R9 reset in_status", in_status, 0);
        chk(err_flag == 0, "R9 reset err_flag", err_flag, 0);

        // R1: nothing happens before the configuration load is done
        cyc(20);
        chk(att == 0, "R1 no transaction before cfg_done", att, 0);
        cfg_done = 1'b1;
        cyc(20);
        chk(wr_ok == 1, "R2 start-up image write count", wr_ok, 1);
        chk(last_wdata == 8'h3C, "R2 start-up image value", last_wdata, 8'h3C);

        out_image = 8'hA5;
        cyc(20);
        chk(wr_ok == 2, "R2 write after change count", wr_ok, 2);
        chk(last_wdata == 8'hA5, "R2 full image written", last_wdata, 8'hA5);

        // R3: changes during a write merge into one further write
        b_wr = wr_ok;
        out_image = 8'h11;
        cyc(4);
        out_image = 8'h22;
        cyc(1);
        out_image = 8'h33;
        cyc(40);
        chk(wr_ok == b_wr + 2, "R3 one follow-up write", wr_ok, b_wr + 2);
        chk(last_wdata == 8'h33, "R3 follow-up carries latest image", last_wdata, 8'h33);

        // R4: interrupt ignored while the alternate function is off
        b_att = att;
        exp_int_n = 1'b0;
        cyc(20);
        chk(att == b_att, "R4 interrupt ignored when disabled", att, b_att);
        chk(rd_ok == 0, "R4 no read when disabled", rd_ok, 0);

        rd_val = 8'h5A;
        int_alt_en = 1'b1;
        cyc(12);
        chk(rd_ok >= 1, "R4 read issued on enabled interrupt", rd_ok, 1);
        chk(in_status == 8'h5A, "R9 captured input byte", in_status, 8'h5A);
        rd_val = 8'h96;
        cyc(18);
        exp_int_n = 1'b1;
        cyc(20);
        b_rd = rd_ok;
        chk(b_rd >= 3, "R5 repeated reads while low", b_rd, 3);
        chk(in_status == 8'h96, "R9 latest read byte", in_status, 8'h96);
        cyc(20);
        chk(rd_ok == b_rd, "R5 reads stop when high", rd_ok, b_rd);

        // R6: write wins over read when both are pending
        cfg_done = 1'b0;
        cyc(5);
        exp_int_n = 1'b0;
        out_image = 8'hC3;
        cyc(10);
        arm_first = 1;
        first_kind = -1;
        cfg_done = 1'b1;
        cyc(25);
        chk(first_kind == 1, "R6 write launched before read", first_kind, 1);
        exp_int_n = 1'b1;
        cyc(25);

        // R8: one NACK -> retry succeeds, error sticky
        chk(err_flag == 0, "R8 no error before NACK", err_flag, 0);
        b_wr = wr_ok; b_att = att;
        nack_left = 1;
        out_image = 8'h0F;
        cyc(30);
        chk(wr_ok == b_wr + 1, "R8 retry completes the write", wr_ok, b_wr + 1);
        chk(att == b_att + 2, "R8 exactly one retry", att, b_att + 2);
        chk(last_wdata == 8'h0F, "R8 retry carries same data", last_wdata, 8'h0F);
        chk(err_flag == 1, "R8 error flag set", err_flag, 1);

        // R8: two NACKs -> transaction dropped
        b_wr = wr_ok; b_att = att;
        nack_left = 2;
        out_image = 8'hF0;
        cyc(30);
        chk(wr_ok == b_wr, "R8 dropped after second NACK", wr_ok, b_wr);
        chk(att == b_att + 2, "R8 no third attempt", att, b_att + 2);
        out_image = 8'h55;
        cyc(25);
        chk(wr_ok == b_wr + 1, "R8 later change written", wr_ok, b_wr + 1);
        chk(last_wdata == 8'h55, "R8 later image value", last_wdata, 8'h55);
        chk(err_flag == 1, "R8 error flag sticky", err_flag, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule